// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit expands one multi-register memory transfer into a series of word accesses. A caller supplies a register-select mask, a base address, an addressing mode and a load/store flag, then pulses `start`. The unit then issues one beat per clock. Each beat pairs a register number with a word address. Registers are always walked from the lowest-numbered selected bit upward, at ascending addresses, whatever the direction of the mode. The mode only decides where the lowest address sits relative to the base, and what the base becomes afterwards.

Four primary modes are offered: increment-after, increment-before, decrement-after and decrement-before. Four stack-style aliases (full/empty combined with ascending/descending) are resolved onto those primary modes. They resolve differently for loads and stores, so that a push and its matching pop pair up. When writeback is enabled, the unit reports an updated base. When it is disabled, the reported base is the original one. The memory bus and the register file sit outside the block.

Top module: `blockXferSeq`

## Requirements
- R1: In increment-after mode (modeSel=0), the first beat carries the base address and each later beat adds 4.
- R2: Beats visit the set bits of regMask in ascending bit order, one per beat, and beat k (counting from 0) uses address lowest+4·k.
- R3: In increment-before mode (modeSel=1), the first beat address is base+4.
- R4: In decrement-after mode (modeSel=2), with n selected registers, the first beat address is base−4·n+4.
- R5: In decrement-before mode (modeSel=3), with n selected registers, the first beat address is base−4·n.
- R6: With wbEn=1, wbAddr after completion is base+4·n for the increment modes and base−4·n for the decrement modes.
- R7: With wbEn=0, wbAddr after completion equals the base address.
- R8: For a store (isStore=1), aliases map as follows: full-descending (modeSel=4) to decrement-before, full-ascending (5) to increment-before, empty-descending (6) to decrement-after, and empty-ascending (7) to increment-after.
- R9: For a load (isStore=0), aliases map as follows: full-descending (4) to increment-after, full-ascending (5) to decrement-after, empty-descending (6) to increment-before, and empty-ascending (7) to decrement-before.
- R10: After a start accepted at a clock edge, beats appear in the n following cycles with busy high. done is high for exactly one cycle right after the last beat, with busy and beatValid low.
- R11: A start with an all-zero mask produces no beat, raises done in the next cycle, and reports wbAddr equal to the base.
- R12: A start pulse while busy is high is ignored. The running sequence and its inputs stay as latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; accepted only while idle |
| regMask | input | 16 | Register-select mask, bit i selects register i |
| baseAddr | input | 32 | Base address |
| modeSel | input | 3 | 0 IA, 1 IB, 2 DA, 3 DB, 4 full-desc, 5 full-asc, 6 empty-desc, 7 empty-asc |
| isStore | input | 1 | 1 for store, 0 for load; selects the alias mapping |
| wbEn | input | 1 | Enable base writeback |
| busy | output | 1 | High while beats are being issued |
| done | output | 1 | One-cycle completion pulse |
| beatValid | output | 1 | Current beat is valid |
| beatReg | output | 4 | Register number of the current beat |
| beatAddr | output | 32 | Word address of the current beat |
| wbAddr | output | 32 | Updated base, valid from the done cycle |

## Verification
A wrong starting address from the mode decode shows up on the first beat, one cycle after start. A faulty address increment shows up on the second beat. A bad mask-drain or priority encoder gives a wrong beatReg, or a beat count that differs from the mask population, so done moves earlier or later than the cycle after the last expected beat. Errors in the alias tables or the writeback arithmetic surface at the latest in the done cycle through wbAddr. The sweep over all eight mode codes, both directions and both writeback settings reaches each of these paths.

// File: rtl/xferSeqPkg.sv
package xferSeqPkg;

  typedef enum logic [1:0] {
    WALK_IA = 2'd0,
    WALK_IB = 2'd1,
    WALK_DA = 2'd2,
    WALK_DB = 2'd3
  } walkMode_e;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

  // Resolve the 3-bit mode selector (primary or stack alias) to a walk mode.
  function automatic walkMode_e resolveMode(input logic [2:0] sel, input logic isStore);
    walkMode_e m;
    case (sel)
      3'd0: m = WALK_IA;
      3'd1: m = WALK_IB;
      3'd2: m = WALK_DA;
      3'd3: m = WALK_DB;
      3'd4: m = isStore ? WALK_DB : WALK_IA;  // full descending
      3'd5: m = isStore ? WALK_IB : WALK_DA;  // full ascending
      3'd6: m = isStore ? WALK_DA : WALK_IB;  // empty descending
      default: m = isStore ? WALK_IA : WALK_DB;  // empty ascending
    endcase
    return m;
  endfunction

endpackage

// File: rtl/xferSeqPath.sv
module xferSeqPath
  import xferSeqPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_CNT    = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strb,
  input  logic [REG_CNT-1:0]         regMask,
  input  logic [ADDR_W-1:0]          baseAddr,
  input  walkMode_e                  mode,
  input  logic                       wbEn,
  output logic                       maskEmpty,
  output logic                       lastBeat,
  output logic [$clog2(REG_CNT)-1:0] beatReg,
  output logic [ADDR_W-1:0]          beatAddr,
  output logic [ADDR_W-1:0]          wbAddr
);

  localparam int IDX_W = $clog2(REG_CNT);
  localparam int CNT_W = $clog2(REG_CNT + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [REG_CNT-1:0] maskR;
  logic [ADDR_W-1:0]  addrR;
  logic [ADDR_W-1:0]  wbR;
  logic [REG_CNT-1:0] maskNext;
  logic [CNT_W-1:0]   selCount;
  logic [ADDR_W-1:0]  span;
  logic [ADDR_W-1:0]  lowAddr;
  logic [ADDR_W-1:0]  endAddr;
  logic [IDX_W-1:0]   lowIdx;

  // population count of the incoming mask
  always_comb begin
    selCount = '0;
    for (int i = 0; i < REG_CNT; i++) selCount = selCount + CNT_W'(regMask[i]);
  end

  assign span = ADDR_W'(selCount) * STEP;

  always_comb begin
    case (mode)
      WALK_IA: begin lowAddr = baseAddr;               endAddr = baseAddr + span; end
      WALK_IB: begin lowAddr = baseAddr + STEP;        endAddr = baseAddr + span; end
      WALK_DA: begin lowAddr = baseAddr - span + STEP; endAddr = baseAddr - span; end
      default: begin lowAddr = baseAddr - span;        endAddr = baseAddr - span; end
    endcase
  end

  // lowest set bit of the remaining mask
  always_comb begin
    lowIdx = '0;
    for (int i = REG_CNT - 1; i >= 0; i--) if (maskR[i]) lowIdx = IDX_W'(i);
  end

  assign maskNext  = maskR & (maskR - 1'b1);
  assign lastBeat  = (maskNext == '0);
  assign maskEmpty = (regMask == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskR <= '0;
      addrR <= '0;
      wbR   <= '0;
    end else if (strb.load) begin
      maskR <= regMask;
      addrR <= lowAddr;
      wbR   <= wbEn ? endAddr : baseAddr;
    end else if (strb.step) begin
      maskR <= maskNext;
      addrR <= addrR + STEP;
    end
  end

  assign beatReg  = lowIdx;
  assign beatAddr = addrR;
  assign wbAddr   = wbR;

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.step) && !$past(strb.load) |-> addrR == $past(addrR) + STEP);

  // R2
  beat_reg_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> maskR[beatReg]);

  // R2
  mask_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.step) && !$past(strb.load) |-> $countones(maskR) + 1 == $countones($past(maskR)));

endmodule

// File: rtl/xferSeqCtl.sv
module xferSeqCtl
  import xferSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       maskEmpty,
  input  logic       lastBeat,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;
  ctlState_e state;

  always_comb begin
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (maskEmpty) done <= 1'b1;
          else           state <= ST_RUN;
        end
        default: if (lastBeat) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  assign busy = (state == ST_RUN);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && lastBeat |=> done && !busy);

  // R11
  empty_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start && maskEmpty |=> done && !busy);

  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastBeat |=> busy && !done);

endmodule

// File: rtl/blockXferSeq.sv
module blockXferSeq
  import xferSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] regMask,
  input  logic [31:0] baseAddr,
  input  logic [2:0]  modeSel,
  input  logic        isStore,
  input  logic        wbEn,
  output logic        busy,
  output logic        done,
  output logic        beatValid,
  output logic [3:0]  beatReg,
  output logic [31:0] beatAddr,
  output logic [31:0] wbAddr
);

  seqStrobe_t strb;
  logic       maskEmpty;
  logic       lastBeat;
  walkMode_e  walkMode;

  assign walkMode = resolveMode(modeSel, isStore);

  xferSeqCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .maskEmpty (maskEmpty),
    .lastBeat  (lastBeat),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  xferSeqPath #(
    .ADDR_W     (32),
    .REG_CNT    (16),
    .WORD_BYTES (4)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regMask   (regMask),
    .baseAddr  (baseAddr),
    .mode      (walkMode),
    .wbEn      (wbEn),
    .maskEmpty (maskEmpty),
    .lastBeat  (lastBeat),
    .beatReg   (beatReg),
    .beatAddr  (beatAddr),
    .wbAddr    (wbAddr)
  );

  assign beatValid = busy;

endmodule

// File: tb/blockXferSeq_tb.sv
module blockXferSeq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regMask = '0;
  logic [31:0] baseAddr = '0;
  logic [2:0]  modeSel = '0;
  logic        isStore = 1'b0;
  logic        wbEn = 1'b0;
  logic        busy, done, beatValid;
  logic [3:0]  beatReg;
  logic [31:0] beatAddr, wbAddr;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  blockXferSeq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .regMask(regMask), .baseAddr(baseAddr),
    .modeSel(modeSel), .isStore(isStore), .wbEn(wbEn), .busy(busy), .done(done),
    .beatValid(beatValid), .beatReg(beatReg), .beatAddr(beatAddr), .wbAddr(wbAddr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // primary walk mode: 0 IA, 1 IB, 2 DA, 3 DB
  function automatic int walkOf(input int sel, input bit st);
    case (sel)
      0, 1, 2, 3: return sel;
      4: return st ? 3 : 0;
      5: return st ? 1 : 2;
      6: return st ? 2 : 1;
      default: return st ? 0 : 3;
    endcase
  endfunction

  function automatic string reqOf(input int sel, input bit st, input int w);
    if (sel >= 4) return st ? "R8" : "R9";
    case (w)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic runOne(input logic [15:0] m, input logic [31:0] b, input int sel,
                        input bit st, input bit wb, input bit bump);
    int n, w, k;
    logic [31:0] low, fin;
    string rq;
    n = $countones(m);
    w = walkOf(sel, st);
    rq = reqOf(sel, st, w);
    case (w)
      0: begin low = b;             fin = b + 4 * n; end
      1: begin low = b + 4;         fin = b + 4 * n; end
      2: begin low = b - 4 * n + 4; fin = b - 4 * n; end
      default: begin low = b - 4 * n; fin = b - 4 * n; end
    endcase
    if (!wb) fin = b;
    @(negedge clk);
    regMask = m; baseAddr = b; modeSel = 3'(sel); isStore = st; wbEn = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check("R11 done", {31'd0, done}, 32'd1);
      check("R11 beat", {31'd0, beatValid}, 32'd0);
      check("R11 wb", wbAddr, b);
      return;
    end
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        check("R10 valid", {30'd0, beatValid, done}, 32'd2);
        check("R2 reg", {28'd0, beatReg}, i);
        check(k == 0 ? rq : "R2 addr", beatAddr, low + 4 * k);
        if (bump && k == 0) begin
          // R12: conflicting request while busy
          start = 1'b1; regMask = ~m; baseAddr = b ^ 32'h00F0_0000; modeSel = 3'(sel ^ 1);
        end
        @(negedge clk);
        start = 1'b0;
        k++;
      end
    end
    check("R10 done", {29'd0, done, busy, beatValid}, 32'd4);
    check(bump ? "R12 wb" : (wb ? "R6 wb" : "R7 wb"), wbAddr, fin);
  endtask

  initial begin
    logic [15:0] masks [8];
    masks[0] = 16'h0000; masks[1] = 16'h0001; masks[2] = 16'h8000; masks[3] = 16'h0007;
    masks[4] = 16'hA5A5; masks[5] = 16'hFFFF; masks[6] = 16'h0420; masks[7] = 16'h7FFE;
    repeat (3) @(negedge clk);
    check("R10 reset busy", {31'd0, busy}, 32'd0);
    check("R10 reset done", {31'd0, done}, 32'd0);
    check("R10 reset valid", {31'd0, beatValid}, 32'd0);
    rstN = 1'b1;
    // reference case: three registers from 0x1000
    runOne(16'h0007, 32'h1000, 0, 1'b1, 1'b1, 1'b0);
    runOne(16'h0007, 32'h1000, 1, 1'b1, 1'b1, 1'b0);
    for (int s = 0; s < 8; s++)
      for (int st = 0; st < 2; st++)
        for (int wb = 0; wb < 2; wb++)
          for (int mi = 0; mi < 8; mi++)
            runOne(masks[mi], 32'h0000_8000 + 32'(s * 256 + mi * 16), s, st[0], wb[0], 1'b0);
    // R12: start pulses during busy are ignored
    runOne(16'h0F0F, 32'h0002_0000, 0, 1'b0, 1'b1, 1'b1);
    runOne(16'h1111, 32'h0003_0000, 3, 1'b1, 1'b1, 1'b1);
    // back-to-back and wraparound near address zero
    runOne(16'h00FF, 32'h0000_0010, 3, 1'b1, 1'b1, 1'b0);
    runOne(16'h0003, 32'hFFFF_FFF8, 0, 1'b0, 1'b1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule